// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns the 4-bit transmit nibbles of a 100 Mb/s MAC into a serial line code, one bit per 125 MHz clock. Every five clocks it takes one nibble and maps it to a five-bit symbol. Idle and the frame delimiters are symbols too, so they pass through the same code stage. The symbol bits are sent one at a time. In copper mode each bit is XORed with an 11-bit LFSR key stream. The result is NRZI coded and then mapped onto a three-level line code. In fiber mode the key stream and the three-level stage are skipped, and the unscrambled NRZI bit is the useful output.

The MAC watches `nib_req`. When it is high, the next rising clock edge samples `tx_en` and `txd`. The mode input may change at any clock. The new mode applies from the next bit on, and no state is cleared.

Top module: `fe_tx_line_encoder`

## Requirements
- R1: After a synchronous reset, `nrzi_out` is 0, `line_lvl` is the zero level, and the first symbol sent is idle. `nib_req` is low in the first four clocks after reset and first goes high in the fifth.
- R2: `nib_req` is high for exactly one clock in every five. `tx_en` and `txd` are sampled only at the rising edge that ends such a clock.
- R3: If `tx_en` is sampled high while the encoder is idle, the encoder sends J (11000) and then K (10001). The two nibbles sampled at those points are discarded, and data symbols follow.
- R4: While a frame is running and `tx_en` is sampled high, the encoder sends the data code of `txd`: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: If `tx_en` is sampled low while a frame is running, the encoder sends T (01101) and then R (00111), and then returns to idle. Whatever is sampled at the R point has no effect.
- R6: While idle and with `tx_en` sampled low, the encoder sends the idle symbol 11111.
- R7: The bits of each symbol go out in the order the code is written above, leftmost bit first.
- R8: In copper mode each symbol bit is XORed with bit 11 (the oldest stage) of an LFSR with polynomial x^11 + x^9 + 1. The LFSR is seeded to all ones at reset and steps every clock, in either mode, so its key stream repeats every 2047 bits.
- R9: `nrzi_out` toggles when the coded bit (scrambled in copper mode, plain in fiber mode) is 1 and holds when it is 0. It changes at the clock edge that consumes that bit.
- R10: `line_lvl` encodes 00 as zero, 01 as +1 and 11 as −1. In copper mode it moves one step through the cycle 0, +1, 0, −1 on each coded 1 and holds on a 0. It never jumps straight between +1 and −1.
- R11: In fiber mode the scrambler is bypassed and `line_lvl` holds its level.
- R12: A change of `fiber_mode` at any clock, including in the middle of a symbol, applies from the very next bit. It does not reset the LFSR, the NRZI state or the three-level state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst | input | 1 | synchronous reset, active high |
| fiber_mode | input | 1 | 1 = fiber mode (no scrambling, no three-level stage) |
| tx_en | input | 1 | frame valid from the MAC |
| txd | input | 4 | transmit nibble from the MAC |
| nib_req | output | 1 | next rising edge samples tx_en and txd |
| nrzi_out | output | 1 | NRZI line bit |
| line_lvl | output | 2 | three-level line code: 00 zero, 01 +1, 11 −1 |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is the end of one frame and the start of the next. The bench raises `tx_en` again in the same slot that is sampled for the R symbol, and then in the slot that follows. The encoder must ignore the first and answer the second with J, and never with a data symbol. The second pair is a mode change and a symbol load. The bench flips `fiber_mode` in the very clock in which `nib_req` is high, in the middle of a frame. A behavioural reference model, which keeps its bits in a queue, checks every clock that the NRZI bit and the line level follow the new mode from the next bit on, and that the key stream carries on without a break.

// File: rtl/fe_enc_pkg.sv
package fe_enc_pkg;

  localparam int SYM_W = 5;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_K    = 2'd1,
    FR_DATA = 2'd2,
    FR_R    = 2'd3
  } fr_state_e;

  // Control symbols in written order (leftmost bit is sent first)
  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;

  // Three-level line codes
  localparam logic [1:0] LVL_ZERO = 2'b00;
  localparam logic [1:0] LVL_POS  = 2'b01;
  localparam logic [1:0] LVL_NEG  = 2'b11;

  function automatic logic [SYM_W-1:0] data_symbol(input logic [3:0] nib);
    logic [SYM_W-1:0] s;
    case (nib)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  // Reverse so that the serializer can always shift out bit 0
  function automatic logic [SYM_W-1:0] send_order(input logic [SYM_W-1:0] s);
    logic [SYM_W-1:0] r;
    for (int i = 0; i < SYM_W; i++) r[i] = s[SYM_W-1-i];
    return r;
  endfunction

  // Phase 0,1,2,3 of the three-level cycle -> 0, +1, 0, -1
  function automatic logic [1:0] phase_level(input logic [1:0] ph);
    logic [1:0] l;
    case (ph)
      2'd1:    l = LVL_POS;
      2'd3:    l = LVL_NEG;
      default: l = LVL_ZERO;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/fe_symbol_framer.sv
module fe_symbol_framer
  import fe_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_en,
  input  logic [3:0] txd,
  output logic       code_bit,
  output logic       nib_req
);

  localparam int CNT_W = $clog2(SYM_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

  fr_state_e        state, nxt_state;
  logic [SYM_W-1:0] shreg;
  logic [SYM_W-1:0] nxt_code;
  logic [CNT_W-1:0] cnt;
  logic             load;

  assign load     = (cnt == LAST);
  assign nib_req  = load;
  assign code_bit = shreg[0];

  always_comb begin
    nxt_state = state;
    nxt_code  = SYM_IDLE;
    case (state)
      FR_IDLE: if (tx_en) begin
        nxt_code  = SYM_J;
        nxt_state = FR_K;
      end
      FR_K: begin
        nxt_code  = SYM_K;
        nxt_state = FR_DATA;
      end
      FR_DATA: if (tx_en) begin
        nxt_code = data_symbol(txd);
      end else begin
        nxt_code  = SYM_T;
        nxt_state = FR_R;
      end
      default: begin
        nxt_code  = SYM_R;
        nxt_state = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FR_IDLE;
      shreg <= send_order(SYM_IDLE);
      cnt   <= '0;
    end else if (load) begin
      state <= nxt_state;
      shreg <= send_order(nxt_code);
      cnt   <= '0;
    end else begin
      shreg <= {1'b0, shreg[SYM_W-1:1]};
      cnt   <= cnt + 1'b1;
    end
  end

  // R2
  req_gap_chk: assert property (@(posedge clk) disable iff (rst)
    nib_req |=> !nib_req);

  // R3
  frame_open_chk: assert property (@(posedge clk) disable iff (rst)
    (load && state == FR_IDLE && tx_en) |=> (state == FR_K));

  // R5
  frame_close_chk: assert property (@(posedge clk) disable iff (rst)
    (load && state == FR_DATA && !tx_en) |=> (state == FR_R));

endmodule

// File: rtl/fe_scrambler.sv
module fe_scrambler #(
  parameter int               LFSR_W = 11,
  parameter int               TAP    = 9,
  parameter logic [LFSR_W-1:0] SEED  = '1
) (
  input  logic clk,
  input  logic rst,
  output logic key_bit
);

  logic [LFSR_W-1:0] lfsr;
  logic              fb;

  assign fb      = lfsr[LFSR_W-1] ^ lfsr[TAP-1];
  assign key_bit = lfsr[LFSR_W-1];

  always_ff @(posedge clk) begin
    if (rst) lfsr <= SEED;
    else     lfsr <= {lfsr[LFSR_W-2:0], fb};
  end

  // R8
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);

endmodule

// File: rtl/fe_line_coder.sv
module fe_line_coder
  import fe_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fiber_mode,
  input  logic       code_bit,
  input  logic       key_bit,
  output logic       nrzi_out,
  output logic [1:0] line_lvl
);

  logic       tx_one;
  logic       nrzi_q;
  logic [1:0] phase;

  assign tx_one   = fiber_mode ? code_bit : (code_bit ^ key_bit);
  assign nrzi_out = nrzi_q;
  assign line_lvl = phase_level(phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      nrzi_q <= 1'b0;
      phase  <= 2'd0;
    end else begin
      nrzi_q <= nrzi_q ^ tx_one;
      if (!fiber_mode && tx_one) phase <= phase + 2'd1;
    end
  end

  // R9
  nrzi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_one |=> $stable(nrzi_q));

  // R10
  no_rail_jump_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(line_lvl) == LVL_POS) |-> (line_lvl != LVL_NEG));

  // R11
  fiber_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fiber_mode |=> $stable(line_lvl));

endmodule

// File: rtl/fe_tx_line_encoder.sv
module fe_tx_line_encoder #(
  parameter int LFSR_W = 11,
  parameter int TAP    = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fiber_mode,
  input  logic       tx_en,
  input  logic [3:0] txd,
  output logic       nib_req,
  output logic       nrzi_out,
  output logic [1:0] line_lvl
);

  logic code_bit;
  logic key_bit;

  fe_symbol_framer u_framer (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .txd      (txd),
    .code_bit (code_bit),
    .nib_req  (nib_req)
  );

  fe_scrambler #(.LFSR_W(LFSR_W), .TAP(TAP), .SEED('1)) u_scr (
    .clk     (clk),
    .rst     (rst),
    .key_bit (key_bit)
  );

  fe_line_coder u_coder (
    .clk        (clk),
    .rst        (rst),
    .fiber_mode (fiber_mode),
    .code_bit   (code_bit),
    .key_bit    (key_bit),
    .nrzi_out   (nrzi_out),
    .line_lvl   (line_lvl)
  );

endmodule

// File: tb/fe_tx_line_encoder_tb.sv
module fe_tx_line_encoder_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fiber_mode = 1'b0;
  logic       tx_en = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       nib_req;
  logic       nrzi_out;
  logic [1:0] line_lvl;

  int n_chk = 0;
  int n_fail = 0;
  string stg = "R1";

  always #4 clk = ~clk;

  fe_tx_line_encoder u_dut (
    .clk(clk), .rst(rst), .fiber_mode(fiber_mode), .tx_en(tx_en), .txd(txd),
    .nib_req(nib_req), .nrzi_out(nrzi_out), .line_lvl(line_lvl)
  );

  // Code values in written order, leftmost bit sent first
  int tbl[16] = '{30, 9, 20, 21, 10, 11, 14, 15, 18, 19, 22, 23, 26, 27, 28, 29};
  localparam int C_I = 31, C_J = 24, C_K = 17, C_T = 13, C_R = 7;

  // ---------------- Behavioural reference model ----------------
  int mq[$];
  int mst, ml, mnz, mph;
  bit live = 0;

  task automatic push_code(int c);
    for (int i = 4; i >= 0; i--) mq.push_back((c >> i) & 1);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      push_code(C_I);
      mst = 0; ml = 'h7FF; mnz = 0; mph = 0;
      live = 1;
    end else if (live) begin
      int b, key, s, c;
      b   = mq.pop_front();
      key = (ml >> 10) & 1;
      s   = fiber_mode ? b : (b ^ key);
      mnz = mnz ^ s;
      if (!fiber_mode && s == 1) mph = (mph + 1) % 4;
      ml  = ((ml << 1) & 'h7FF) | (((ml >> 10) ^ (ml >> 8)) & 1);
      if (mq.size() == 0) begin
        c = C_I;
        if (mst == 0) begin
          if (tx_en) begin c = C_J; mst = 1; end
        end else if (mst == 1) begin
          c = C_K; mst = 2;
        end else if (mst == 2) begin
          if (tx_en) c = tbl[txd];
          else begin c = C_T; mst = 3; end
        end else begin
          c = C_R; mst = 0;
        end
        push_code(c);
      end
    end
  end

  function automatic int lvl_code(int ph);
    if (ph == 1) return 1;
    if (ph == 3) return 3;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (!rst && live) begin
      int er;
      n_chk += 3;
      if (nrzi_out !== mnz[0]) begin
        n_fail++;
        $display("FAIL R8/R9 %s nrzi got %0d exp %0d at %0t", stg, nrzi_out, mnz, $time);
      end
      er = lvl_code(mph);
      if (line_lvl !== er[1:0]) begin
        n_fail++;
        $display("FAIL R10 %s line_lvl got %0d exp %0d at %0t", stg, line_lvl, er, $time);
      end
      if (nib_req !== (mq.size() == 1)) begin
        n_fail++;
        $display("FAIL R2 nib_req got %0d exp %0d at %0t", nib_req, mq.size() == 1, $time);
      end
    end
  end

  // ---------------- Fiber-mode symbol monitor ----------------
  int    exp_q[$];
  string tag_q[$];
  int    mc = 9, acc = 0;
  bit    act = 0;
  logic  prevn = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      mc = 9; act = 0;
    end else begin
      int b;
      b = nrzi_out ^ prevn;
      if (nib_req) mc = 0; else mc++;
      if (mc == 2 && exp_q.size() > 0) begin
        act = 1; acc = b;
      end else if (act && (mc == 3 || mc == 4 || mc == 0)) begin
        acc = (acc << 1) | b;
      end else if (act && mc == 1) begin
        int e;
        string t;
        acc = (acc << 1) | b;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (acc != e) begin
          n_fail++;
          $display("FAIL %s symbol got %b exp %b at %0t", t, acc[4:0], e[4:0], $time);
        end
        act = 0;
      end
    end
    prevn = nrzi_out;
  end

  // ---------------- Stimulus ----------------
  task automatic put(input logic en, input logic [3:0] d);
    @(negedge clk);
    while (!nib_req) @(negedge clk);
    tx_en = en;
    txd   = d;
  endtask

  task automatic fput(input logic en, input logic [3:0] d, input int e, input string t);
    put(en, d);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: one edge after reset release
    n_chk += 3;
    if (nrzi_out !== 1'b0) begin n_fail++; $display("FAIL R1 nrzi got %0d exp 0", nrzi_out); end
    if (line_lvl !== 2'b00) begin n_fail++; $display("FAIL R1 line_lvl got %0d exp 0", line_lvl); end
    if (nib_req !== 1'b0) begin n_fail++; $display("FAIL R1 nib_req got %0d exp 0", nib_req); end
    repeat (3) @(negedge clk);
    n_chk++;
    if (nib_req !== 1'b1) begin n_fail++; $display("FAIL R1 first nib_req got %0d exp 1", nib_req); end

    // Copper frame, all nibble values
    stg = "R3"; put(1, 4'h5); put(1, 4'h5);
    stg = "R4";
    for (int d = 0; d < 16; d++) put(1, 4'(d));
    stg = "R5"; put(0, 0); put(1, 4'h7);     // R slot ignores tx_en
    put(1, 4'h5); put(1, 4'h5);              // restart: J, K
    put(1, 4'hA); put(1, 4'h3); put(0, 0); put(0, 0);
    stg = "R6"; repeat (6) put(0, 0);

    // Long run over the key stream period
    stg = "R8"; repeat (2100) @(negedge clk);

    // Fiber mode: decode symbols from NRZI
    stg = "R11"; fiber_mode = 1'b1;
    repeat (12) @(negedge clk);
    fput(0, 0, C_I, "R6");
    fput(1, 4'h5, C_J, "R3"); fput(1, 4'h5, C_K, "R3");
    fput(1, 4'h1, tbl[1], "R7");
    for (int d = 0; d < 16; d++) fput(1, 4'(d), tbl[d], "R4");
    fput(0, 0, C_T, "R5"); fput(1, 4'h3, C_R, "R5");
    fput(1, 4'h3, C_J, "R3"); fput(1, 4'h3, C_K, "R3");
    fput(1, 4'hC, tbl[12], "R4");
    fput(0, 0, C_T, "R5"); fput(0, 0, C_R, "R5");
    fput(0, 0, C_I, "R6"); fput(0, 0, C_I, "R6");
    repeat (12) @(negedge clk);

    // Mode change at a symbol load, mid-frame, and mid-symbol
    stg = "R12"; fiber_mode = 1'b0;
    put(1, 4'h5); put(1, 4'h5); put(1, 4'h9);
    put(1, 4'h6); fiber_mode = 1'b1;
    put(1, 4'hE); put(1, 4'h2);
    @(negedge clk); @(negedge clk); fiber_mode = 1'b0;
    put(1, 4'hF); put(0, 0); put(0, 0);
    repeat (40) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule